// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

The block holds eight token latches that two independent ports share to agree on who may use a common resource. A port asks for a token by writing a 0 to it. It then reads the token back to find out whether the request won. It gives the token up by writing a 1. Only one port owns a token at any moment. A request against a token that the other port holds is remembered, and it is granted as soon as the holder lets go.

Each port selects the bank with its own semaphore-select strobe. This keeps token traffic apart from ordinary memory traffic on the same address lines. The token number is taken from the lowest address bits. When both ports ask for the same free token on the same clock edge, the left port wins every time. A read returns the token state replicated across the whole data word: all zeros to the owner and all ones to any other reader.

Top module: `sem_unit`

## Requirements
- R1: After reset every token is free. A read of any token by either port then returns all ones (0xFFFF at the default 16-bit width).
- R2: A write of data bit 0 to a free token by a port gives that port ownership from the next clock edge. From then on the owner reads all zeros and the other port reads all ones.
- R3: A token has at most one owner. A write of 0 by the non-owner does not take the token, and the non-owner still reads all ones.
- R4: When both ports write 0 to the same free token in the same cycle, the left port becomes the owner.
- R5: A write of data bit 1 by the owner releases the token. If the other port has an unwithdrawn request pending, that port owns the token from the next edge. Otherwise the token becomes free.
- R6: A write of 1 by a port that does not own the token leaves the owner unchanged. The write withdraws that port's pending request, so a later release by the owner leaves the token free.
- R7: The token number is address bits [2:0]. Higher address bits have no effect, and each token is independent of the others.
- R8: An access needs its port's select asserted. A read needs select high, output enable high and write low. On any cycle that is not a read, the port's read data is all zeros, and a write with select low changes no token.
- R9: Read data reflects token state combinationally. A read issued in the same cycle as a write by the other port returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sel | input | 1 | Left port semaphore select |
| l_addr | input | ADDR_W | Left port address; low bits pick the token |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port output enable |
| l_wbit | input | 1 | Left port write data: 0 requests, 1 releases |
| l_rdata | output | DATA_W | Left port read word, every bit the token state |
| r_sel | input | 1 | Right port semaphore select |
| r_addr | input | ADDR_W | Right port address; low bits pick the token |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port output enable |
| r_wbit | input | 1 | Right port write data: 0 requests, 1 releases |
| r_rdata | output | DATA_W | Right port read word, every bit the token state |

## Verification
The bench builds the block with its defaults: eight tokens, a 14-bit address and a 16-bit word. The wide address lets it reach the same token through addresses that differ only in their upper bits. The 16-bit word shows that the token state is replicated into every data bit rather than only bit 0. The scenarios cover:
- a pending request being handed the token on release;
- a request withdrawn before the release;
- the same-cycle tie between the two ports;
- a read that overlaps a release in the same cycle;
- a reset taken while tokens are held.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
endpackage

// File: rtl/sem_port_dec.sv
// Decodes one port's strobes into per-token claim/drop pulses and a read flag.
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 14,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic               oe,
  input  logic               wbit,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SEM-1:0] claim,
  output logic [NUM_SEM-1:0] drop,
  output logic               rd
);
  logic unused_addr_hi;

  assign idx            = addr[IDX_W-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W];
  assign rd             = sel & oe & ~we;

  always_comb begin
    claim = '0;
    drop  = '0;
    if (sel && we) begin
      if (wbit) drop[idx]  = 1'b1;
      else      claim[idx] = 1'b1;
    end
  end
endmodule

// File: rtl/sem_cell.sv
// One token: two request flags and the owner field.
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_claim,
  input  logic l_drop,
  input  logic r_claim,
  input  logic r_drop,
  output logic own_l,
  output logic own_r
);
  logic req_l_q, req_r_q, req_l_d, req_r_d;
  own_e owner_q, owner_d;
  logic upd_en;

  assign upd_en = l_claim | l_drop | r_claim | r_drop;

  always_comb begin
    req_l_d = l_claim ? 1'b1 : (l_drop ? 1'b0 : req_l_q);
    req_r_d = r_claim ? 1'b1 : (r_drop ? 1'b0 : req_r_q);
    owner_d = OWN_NONE;
    unique case (owner_q)
      OWN_LEFT: begin
        if (req_l_d)      owner_d = OWN_LEFT;
        else if (req_r_d) owner_d = OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (req_r_d)      owner_d = OWN_RIGHT;
        else if (req_l_d) owner_d = OWN_LEFT;
      end
      default: begin
        if (req_l_d)      owner_d = OWN_LEFT;
        else if (req_r_d) owner_d = OWN_RIGHT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      owner_q <= OWN_NONE;
    end else if (upd_en) begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      owner_q <= owner_d;
    end
  end

  assign own_l = (owner_q == OWN_LEFT);
  assign own_r = (owner_q == OWN_RIGHT);
endmodule

// File: rtl/sem_read_port.sv
// Replicates the addressed token's state over the port's read word.
module sem_read_port #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               rd,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] own_vec,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    if (rd) rdata = {DATA_W{~own_vec[idx]}};
    else    rdata = '0;
  end
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [IDX_W-1:0]   l_idx, r_idx;
  logic [NUM_SEM-1:0] l_claim, l_drop, r_claim, r_drop;
  logic               l_rd, r_rd;
  logic [NUM_SEM-1:0] own_l_vec, own_r_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) l_dec_i (
    .sel(l_sel), .addr(l_addr), .we(l_we), .oe(l_oe), .wbit(l_wbit),
    .idx(l_idx), .claim(l_claim), .drop(l_drop), .rd(l_rd)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) r_dec_i (
    .sel(r_sel), .addr(r_addr), .we(r_we), .oe(r_oe), .wbit(r_wbit),
    .idx(r_idx), .claim(r_claim), .drop(r_drop), .rd(r_rd)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell cell_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .l_claim(l_claim[g]),
      .l_drop (l_drop[g]),
      .r_claim(r_claim[g]),
      .r_drop (r_drop[g]),
      .own_l  (own_l_vec[g]),
      .own_r  (own_r_vec[g])
    );
  end

  sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) l_rp_i (
    .rd(l_rd), .idx(l_idx), .own_vec(own_l_vec), .rdata(l_rdata)
  );

  sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) r_rp_i (
    .rd(r_rd), .idx(r_idx), .own_vec(own_r_vec), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_sel,
  input logic [ADDR_W-1:0]  l_addr,
  input logic               l_we,
  input logic               l_oe,
  input logic               l_wbit,
  input logic [DATA_W-1:0]  l_rdata,
  input logic               r_sel,
  input logic [ADDR_W-1:0]  r_addr,
  input logic               r_we,
  input logic               r_oe,
  input logic               r_wbit,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] own_l_vec,
  input logic [NUM_SEM-1:0] own_r_vec
);
  logic [IDX_W-1:0] li, ri;
  logic l_rd, r_rd, l_w0, r_w0, l_w1, r_w1;
  logic unused_hi;

  assign li        = l_addr[IDX_W-1:0];
  assign ri        = r_addr[IDX_W-1:0];
  assign unused_hi = ^{l_addr[ADDR_W-1:IDX_W], r_addr[ADDR_W-1:IDX_W]};
  assign l_rd      = l_sel & l_oe & ~l_we;
  assign r_rd      = r_sel & r_oe & ~r_we;
  assign l_w0      = l_sel & l_we & ~l_wbit;
  assign r_w0      = r_sel & r_we & ~r_wbit;
  assign l_w1      = l_sel & l_we & l_wbit;
  assign r_w1      = r_sel & r_we & r_wbit;

  // R3
  excl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && r_rd && li == ri) |-> ((&l_rdata) || (&r_rdata)));

  // R2
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_w0 && !own_l_vec[li] && !own_r_vec[li]) |=> own_l_vec[$past(li)]);

  // R4
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_w0 && r_w0 && li == ri && !own_l_vec[li] && !own_r_vec[li])
    |=> (own_l_vec[$past(li)] && !own_r_vec[$past(li)]));

  // R6
  foreign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_w1 && own_r_vec[li] && !(r_sel && r_we && ri == li))
    |=> own_r_vec[$past(li)]);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel && !r_sel) |=> ($stable(own_l_vec) && $stable(own_r_vec)));

  // R5
  hand_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_w1 && own_r_vec[ri] && l_w0 && li == ri) |=> own_l_vec[$past(ri)]);
endmodule

bind sem_unit sem_unit_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .l_sel(l_sel), .l_addr(l_addr), .l_we(l_we), .l_oe(l_oe), .l_wbit(l_wbit), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_addr(r_addr), .r_we(r_we), .r_oe(r_oe), .r_wbit(r_wbit), .r_rdata(r_rdata),
  .own_l_vec(own_l_vec), .own_r_vec(own_r_vec)
);

// File: tb/sem_unit_tb_top.sv
module sem_unit_tb_top;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 16;

  // port operation codes used by the driver
  localparam int OP_IDLE   = 0;
  localparam int OP_RD     = 1;
  localparam int OP_W0     = 2;
  localparam int OP_W1     = 3;
  localparam int OP_OE_NOS = 4; // oe high, select low
  localparam int OP_S_NOOE = 5; // select high, oe low, write low
  localparam int OP_W0_NOS = 6; // write 0 with select low

  typedef struct {
    int                cyc;
    bit                port;
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sel, l_we, l_oe, l_wbit, r_sel, r_we, r_oe, r_wbit;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic [DATA_W-1:0] l_rdata, r_rdata;

  int    n_total = 0;
  int    n_fail  = 0;
  int    drv_cyc = 0;
  bit    done    = 0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  sem_unit #(.NUM_SEM(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_addr(l_addr), .l_we(l_we), .l_oe(l_oe), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_addr(r_addr), .r_we(r_we), .r_oe(r_oe), .r_wbit(r_wbit), .r_rdata(r_rdata)
  );

  function automatic logic [3:0] op_bits(input int op);
    // {sel, we, oe, wbit}
    case (op)
      OP_RD:     return 4'b1010;
      OP_W0:     return 4'b1100;
      OP_W1:     return 4'b1101;
      OP_OE_NOS: return 4'b0010;
      OP_S_NOOE: return 4'b1000;
      OP_W0_NOS: return 4'b0100;
      default:   return 4'b0000;
    endcase
  endfunction

  // ex: -1 no check, 0 expect all zeros, 1 expect all ones
  task automatic step(input int lop, input logic [ADDR_W-1:0] la,
                      input int rop, input logic [ADDR_W-1:0] ra,
                      input int exl, input int exr, input string tag);
    item_t it;
    @(negedge clk);
    drv_cyc++;
    {l_sel, l_we, l_oe, l_wbit} = op_bits(lop);
    {r_sel, r_we, r_oe, r_wbit} = op_bits(rop);
    l_addr = la;
    r_addr = ra;
    if (exl >= 0) begin
      it.cyc = drv_cyc; it.port = 1'b0; it.tag = tag;
      it.exp = (exl == 1) ? '1 : '0;
      sb_q.push_back(it);
    end
    if (exr >= 0) begin
      it.cyc = drv_cyc; it.port = 1'b1; it.tag = tag;
      it.exp = (exr == 1) ? '1 : '0;
      sb_q.push_back(it);
    end
  endtask

  // monitor: compares between edges, after the driver has settled inputs
  always begin
    @(negedge clk);
    #5;
    while (sb_q.size() > 0 && sb_q[0].cyc == drv_cyc) begin
      item_t it;
      logic [DATA_W-1:0] act;
      it  = sb_q.pop_front();
      act = it.port ? r_rdata : l_rdata;
      n_total++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s port: got %h expected %h", it.tag,
                 it.port ? "right" : "left", act, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {l_sel, l_we, l_oe, l_wbit, r_sel, r_we, r_oe, r_wbit} = '0;
    l_addr = '0;
    r_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(OP_IDLE, 0, OP_IDLE, 0, -1, -1, "");

    // R1 reset state
    step(OP_RD, 0, OP_RD, 0, 1, 1, "R1");
    step(OP_RD, 7, OP_RD, 7, 1, 1, "R1");
    // R8 strobes incomplete
    step(OP_OE_NOS, 0, OP_S_NOOE, 0, 0, 0, "R8");
    // R2 left claims token 2
    step(OP_W0, 2, OP_IDLE, 0, -1, -1, "");
    step(OP_RD, 2, OP_RD, 2, 0, 1, "R2");
    // R3 right requests held token
    step(OP_IDLE, 0, OP_W0, 2, -1, -1, "");
    step(OP_RD, 2, OP_RD, 2, 0, 1, "R3");
    // R9 right reads while left releases: sees old state
    step(OP_W1, 2, OP_RD, 2, -1, 1, "R9");
    // R5 pending right granted
    step(OP_RD, 2, OP_RD, 2, 1, 0, "R5");
    // R6 non-owner release, then withdrawn request
    step(OP_W1, 2, OP_IDLE, 0, -1, -1, "");
    step(OP_RD, 2, OP_RD, 2, 1, 0, "R6");
    step(OP_W0, 2, OP_IDLE, 0, -1, -1, "");
    step(OP_W1, 2, OP_IDLE, 0, -1, -1, "");
    step(OP_IDLE, 0, OP_W1, 2, -1, -1, "");
    step(OP_RD, 2, OP_RD, 2, 1, 1, "R6");
    // R4 tie on token 5
    step(OP_W0, 5, OP_W0, 5, -1, -1, "");
    step(OP_RD, 5, OP_RD, 5, 0, 1, "R4");
    step(OP_W1, 5, OP_IDLE, 0, -1, -1, "");
    step(OP_RD, 5, OP_RD, 5, 1, 0, "R5");
    step(OP_IDLE, 0, OP_W1, 5, -1, -1, "");
    step(OP_RD, 5, OP_RD, 5, 1, 1, "R5");
    // R7 upper address bits ignored, tokens independent
    step(OP_W0, 14'h2AB3, OP_IDLE, 0, -1, -1, "");
    step(OP_RD, 14'h0003, OP_RD, 14'h3FFB, 0, 1, "R7");
    step(OP_RD, 14'h1234, OP_RD, 14'h0004, 1, 1, "R7");
    // R8 write with select low changes nothing
    step(OP_IDLE, 0, OP_W0_NOS, 6, -1, -1, "");
    step(OP_RD, 6, OP_RD, 6, 1, 1, "R8");
    // R2 right port claims token 0
    step(OP_IDLE, 0, OP_W0, 0, -1, -1, "");
    step(OP_RD, 0, OP_RD, 0, 1, 0, "R2");
    // R1 reset while tokens 0 and 3 are held
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(OP_IDLE, 0, OP_IDLE, 0, -1, -1, "");
    step(OP_RD, 0, OP_RD, 0, 1, 1, "R1");
    step(OP_RD, 3, OP_RD, 3, 1, 1, "R1");
    step(OP_IDLE, 0, OP_IDLE, 0, -1, -1, "");
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule